// File: doc/BRIEF.md
# JTAG Test Access Port with Chain Selection

This block is a JTAG test access port controller for an embedded test or debug subsystem. A sixteen-state controller is clocked by the test clock and steered by the mode-select line. It keeps a 4-bit instruction register, a bypass bit, a 32-bit identification register loaded from a strap bus, and a 5-bit register that names the scan chain currently in use. Test data registers that live outside the block are reached through a serial port: the test data input is passed out on `ext_si`, and the returning bit on `ext_so` is fed to the test data output.

The current instruction and the selected chain number update on the falling test-clock edge. The controller state code updates on the rising edge. All three are exported so that scan chains around the block can decode when to capture, shift and update. The test data output changes on the falling edge and is driven only while a shift state is active. A flag reports when it is being driven.

Top module: `jtag_chain_tap`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, `tap_state` becomes 4'hF. From the following falling edge, `instr` reads 4'hE (identification), `chain_sel` reads 0, and `tdo_drive` and `tdo` read 0.
- R2: `tap_state` changes only on rising `tck`, to the state chosen by `tms`. Codes: reset F, idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8, update-IR D. The edges with `tms`=0/1 are: F→C/F, C→C/7, 7→6/4, 6→2/1, 2→2/1, 1→3/5, 3→3/0, 0→2/5, 5→C/7, 4→E/F, E→A/9, A→A/9, 9→B/D, B→B/8, 8→A/D, D→C/7.
- R3: In capture-IR the instruction shift register loads 4'b0001. In shift-IR it shifts toward bit 0, with `tdi` entering bit 3, and `tdo` presents bit 0. The first bit out after capture is therefore 1, followed by three 0 bits.
- R4: `instr` takes the shifted value on the falling edge in update-IR and holds it at all other times, including while shifting. Any entry into reset (state F) reloads 4'hE.
- R5: Under instruction 4'hE, capture-DR loads `idcode_strap`, and 32 shifts emit it least significant bit first. `ext_so` has no effect on the result.
- R6: Under instruction 4'hF, the data path is a single bit that captures 0, so `tdo` repeats `tdi` one shift later.
- R7: Under instruction 4'h2, the data path is the 5-bit chain-select register. Capture loads the current `chain_sel`, and `chain_sel` takes the shifted value on the falling edge in update-DR. Under any other instruction, `chain_sel` is unchanged by a data scan. Entry into reset clears it to 0.
- R8: Under every other instruction, `ext_so` is sampled on rising `tck` and appears on `tdo` at the next falling edge. `ext_si` always equals `tdi`.
- R9: After each falling edge, `tdo_drive` is 1 exactly when the state is shift-IR (A) or shift-DR (2). While it is 0, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on both `tck` edges |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| idcode_strap | input | 32 | Identification value: revision [31:28], product [27:12], maker [11:1], bit 0 = 1 |
| ext_so | input | 1 | Serial data returning from an external chain |
| ext_si | output | 1 | Serial data sent to an external chain (copy of `tdi`) |
| tdo | output | 1 | Serial test data out, changes on falling `tck` |
| tdo_drive | output | 1 | High while `tdo` carries shifted data |
| tap_state | output | 4 | Controller state code |
| instr | output | 4 | Current instruction |
| chain_sel | output | 5 | Number of the selected scan chain |

## Verification
The controller is walked for several hundred steps under a pseudo-random `tms` stream, and a table model checks every transition together with the drive flag. This separates wrong edges from wrong encodings.

All sixteen instruction codes are loaded through the instruction register. The bench checks that every code lands intact and that the capture pattern comes back each time. All thirty-two chain numbers are pushed through the select register. Each scan must return the number loaded by the previous scan, which proves capture and update are distinct steps.

Identification, bypass and external scans run with a busy `ext_so`. This shows which data path `tdo` follows under each instruction and that the other sources stay out.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W      = 4;
    localparam int DEF_SEL_W = 5;
    localparam int DEF_ID_W  = 32;

    typedef enum logic [3:0] {
        ST_EXIT2_DR   = 4'h0,
        ST_EXIT1_DR   = 4'h1,
        ST_SHIFT_DR   = 4'h2,
        ST_PAUSE_DR   = 4'h3,
        ST_SELECT_IR  = 4'h4,
        ST_UPDATE_DR  = 4'h5,
        ST_CAPTURE_DR = 4'h6,
        ST_SELECT_DR  = 4'h7,
        ST_EXIT2_IR   = 4'h8,
        ST_EXIT1_IR   = 4'h9,
        ST_SHIFT_IR   = 4'hA,
        ST_PAUSE_IR   = 4'hB,
        ST_IDLE       = 4'hC,
        ST_UPDATE_IR  = 4'hD,
        ST_CAPTURE_IR = 4'hE,
        ST_RESET      = 4'hF
    } tap_state_e;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_SCAN_N    = 4'h2;
    localparam instr_t OP_IDCODE    = 4'hE;
    localparam instr_t OP_BYPASS    = 4'hF;
    localparam instr_t IR_CAPT_PATT = 4'b0001;

    typedef enum logic [1:0] {
        PATH_IDCODE,
        PATH_BYPASS,
        PATH_SELECT,
        PATH_EXTERN
    } dr_path_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_phase_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:      n = m ? ST_RESET      : ST_IDLE;
            ST_IDLE:       n = m ? ST_SELECT_DR  : ST_IDLE;
            ST_SELECT_DR:  n = m ? ST_SELECT_IR  : ST_CAPTURE_DR;
            ST_CAPTURE_DR: n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
            ST_SHIFT_DR:   n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
            ST_EXIT1_DR:   n = m ? ST_UPDATE_DR  : ST_PAUSE_DR;
            ST_PAUSE_DR:   n = m ? ST_EXIT2_DR   : ST_PAUSE_DR;
            ST_EXIT2_DR:   n = m ? ST_UPDATE_DR  : ST_SHIFT_DR;
            ST_UPDATE_DR:  n = m ? ST_SELECT_DR  : ST_IDLE;
            ST_SELECT_IR:  n = m ? ST_RESET      : ST_CAPTURE_IR;
            ST_CAPTURE_IR: n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
            ST_SHIFT_IR:   n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
            ST_EXIT1_IR:   n = m ? ST_UPDATE_IR  : ST_PAUSE_IR;
            ST_PAUSE_IR:   n = m ? ST_EXIT2_IR   : ST_PAUSE_IR;
            ST_EXIT2_IR:   n = m ? ST_UPDATE_IR  : ST_SHIFT_IR;
            ST_UPDATE_IR:  n = m ? ST_SELECT_DR  : ST_IDLE;
            default:       n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_path_e decode_path(input instr_t op);
        dr_path_e p;
        case (op)
            OP_IDCODE: p = PATH_IDCODE;
            OP_BYPASS: p = PATH_BYPASS;
            OP_SCAN_N: p = PATH_SELECT;
            default:   p = PATH_EXTERN;
        endcase
        return p;
    endfunction

    function automatic dr_phase_t dr_phase(input tap_state_e s);
        dr_phase_t ph;
        ph.capture = (s == ST_CAPTURE_DR);
        ph.shift   = (s == ST_SHIFT_DR);
        ph.update  = (s == ST_UPDATE_DR);
        return ph;
    endfunction

    function automatic logic in_shift(input tap_state_e s);
        return (s == ST_SHIFT_DR) || (s == ST_SHIFT_IR);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

    // R2
    reset_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    // R2
    shift_dr_stay_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SHIFT_DR && !tms) |=> (state == ST_SHIFT_DR));

    // R2
    update_ir_exit_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_UPDATE_IR) |=> (state == ST_IDLE || state == ST_SELECT_DR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    output instr_t     instr,
    output logic       ir_lsb
);

    instr_t ir_sr;

    // shift stage, rising edge
    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr <= IR_CAPT_PATT;
        end else if (state == ST_CAPTURE_IR) begin
            ir_sr <= IR_CAPT_PATT;
        end else if (state == ST_SHIFT_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // holding stage, falling edge
    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) begin
            instr <= OP_IDCODE;
        end else if (state == ST_UPDATE_IR) begin
            instr <= ir_sr;
        end
    end

    assign ir_lsb = ir_sr[0];

    // R4
    instr_update_only_chk: assert property (@(posedge tck) disable iff (rst)
        !$stable(instr) |-> (state == ST_UPDATE_IR || state == ST_RESET));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int ID_W  = DEF_ID_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  logic             ext_so,
    input  tap_state_e       state,
    input  instr_t           instr,
    input  logic [ID_W-1:0]  idcode_strap,
    output logic [SEL_W-1:0] chain_sel,
    output logic             dr_lsb
);

    dr_path_e         path;
    dr_phase_t        ph;
    logic [ID_W-1:0]  id_sr;
    logic [SEL_W-1:0] sel_sr;
    logic             byp_q;
    logic             ext_q;

    assign path = decode_path(instr);
    assign ph   = dr_phase(state);

    always_ff @(posedge tck) begin
        if (rst) begin
            id_sr <= '0;
        end else if (path == PATH_IDCODE) begin
            if (ph.capture) begin
                id_sr <= idcode_strap;
            end else if (ph.shift) begin
                id_sr <= {tdi, id_sr[ID_W-1:1]};
            end
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (path == PATH_BYPASS) begin
            if (ph.capture) begin
                byp_q <= 1'b0;
            end else if (ph.shift) begin
                byp_q <= tdi;
            end
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            sel_sr <= '0;
        end else if (path == PATH_SELECT) begin
            if (ph.capture) begin
                sel_sr <= chain_sel;
            end else if (ph.shift) begin
                sel_sr <= {tdi, sel_sr[SEL_W-1:1]};
            end
        end
    end

    // returning serial data sampled on the rising edge
    always_ff @(posedge tck) begin
        if (rst) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_so;
        end
    end

    // chain number is committed on the falling edge
    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) begin
            chain_sel <= '0;
        end else if (ph.update && path == PATH_SELECT) begin
            chain_sel <= sel_sr;
        end
    end

    always_comb begin
        case (path)
            PATH_IDCODE: dr_lsb = id_sr[0];
            PATH_BYPASS: dr_lsb = byp_q;
            PATH_SELECT: dr_lsb = sel_sr[0];
            default:     dr_lsb = ext_q;
        endcase
    end

    // R7
    chain_update_only_chk: assert property (@(posedge tck) disable iff (rst)
        !$stable(chain_sel) |->
            ((state == ST_UPDATE_DR && instr == OP_SCAN_N) || state == ST_RESET));

endmodule

// File: rtl/tap_tdo.sv
module tap_tdo
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       ir_lsb,
    input  logic       dr_lsb,
    output logic       tdo,
    output logic       tdo_drive
);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo       <= 1'b0;
            tdo_drive <= 1'b0;
        end else begin
            tdo_drive <= in_shift(state);
            case (state)
                ST_SHIFT_IR: tdo <= ir_lsb;
                ST_SHIFT_DR: tdo <= dr_lsb;
                default:     tdo <= 1'b0;
            endcase
        end
    end

    // R9
    drive_in_shift_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SHIFT_IR || state == ST_SHIFT_DR) |-> tdo_drive);

    // R9
    quiet_when_idle_chk: assert property (@(posedge tck) disable iff (rst)
        !tdo_drive |-> !tdo);

endmodule

// File: rtl/jtag_chain_tap.sv
module jtag_chain_tap
    import tap_pkg::*;
#(
    parameter int ID_W  = DEF_ID_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [ID_W-1:0]  idcode_strap,
    input  logic             ext_so,
    output logic             ext_si,
    output logic             tdo,
    output logic             tdo_drive,
    output logic [3:0]       tap_state,
    output logic [IR_W-1:0]  instr,
    output logic [SEL_W-1:0] chain_sel
);

    logic       rst;
    tap_state_e state;
    instr_t     cur_instr;
    logic       ir_lsb;
    logic       dr_lsb;

    assign rst = ~trst_n;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .instr  (cur_instr),
        .ir_lsb (ir_lsb)
    );

    tap_dr #(.ID_W(ID_W), .SEL_W(SEL_W)) u_dr (
        .tck          (tck),
        .rst          (rst),
        .tdi          (tdi),
        .ext_so       (ext_so),
        .state        (state),
        .instr        (cur_instr),
        .idcode_strap (idcode_strap),
        .chain_sel    (chain_sel),
        .dr_lsb       (dr_lsb)
    );

    tap_tdo u_tdo (
        .tck       (tck),
        .rst       (rst),
        .state     (state),
        .ir_lsb    (ir_lsb),
        .dr_lsb    (dr_lsb),
        .tdo       (tdo),
        .tdo_drive (tdo_drive)
    );

    assign tap_state = state;
    assign instr     = cur_instr;
    assign ext_si    = tdi;

endmodule

// File: tb/test_jtag_chain_tap.sv
module test_jtag_chain_tap;

    logic        tck = 1'b0;
    logic        trst_n;
    logic        tms;
    logic        tdi;
    logic [31:0] strap;
    logic        ext_so;
    logic        ext_si;
    logic        tdo;
    logic        tdo_drive;
    logic [3:0]  tap_state;
    logic [3:0]  instr;
    logic [4:0]  chain_sel;

    int total = 0;
    int bad   = 0;

    always #10 tck = ~tck;

    jtag_chain_tap i_jtag_chain_tap (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .tdi          (tdi),
        .idcode_strap (strap),
        .ext_so       (ext_so),
        .ext_si       (ext_si),
        .tdo          (tdo),
        .tdo_drive    (tdo_drive),
        .tap_state    (tap_state),
        .instr        (instr),
        .chain_sel    (chain_sel)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic m);
        case (s)
            4'hF: return m ? 4'hF : 4'hC;
            4'hC: return m ? 4'h7 : 4'hC;
            4'h7: return m ? 4'h4 : 4'h6;
            4'h6: return m ? 4'h1 : 4'h2;
            4'h2: return m ? 4'h1 : 4'h2;
            4'h1: return m ? 4'h5 : 4'h3;
            4'h3: return m ? 4'h0 : 4'h3;
            4'h0: return m ? 4'h5 : 4'h2;
            4'h5: return m ? 4'h7 : 4'hC;
            4'h4: return m ? 4'hF : 4'hE;
            4'hE: return m ? 4'h9 : 4'hA;
            4'hA: return m ? 4'h9 : 4'hA;
            4'h9: return m ? 4'hD : 4'hB;
            4'hB: return m ? 4'h8 : 4'hB;
            4'h8: return m ? 4'hD : 4'hA;
            4'hD: return m ? 4'h7 : 4'hC;
            default: return 4'hF;
        endcase
    endfunction

    // one test-clock period; returns just after the falling edge
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #2;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [3:0] v, output logic [3:0] q);
        logic [3:0] held;
        held = instr;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            q[i] = tdo;
            check("R9", "ir shift drive", {31'd0, tdo_drive}, 32'd1);
            check("R4", "instr held in shift", {28'd0, instr}, {28'd0, held});
            step(i == 3, v[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input logic [31:0] din, input logic [31:0] epat,
                           input int n, output logic [31:0] q);
        q = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        ext_so = epat[0];
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            q[i] = tdo;
            if (i + 1 < n) ext_so = epat[i+1];
            step(i == n - 1, din[i]);
        end
        ext_so = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #(150000 * 20);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0]  q4;
        logic [31:0] q;
        logic [3:0]  model;
        logic [15:0] lf;
        logic [4:0]  prev;

        trst_n = 1'b0;
        tms    = 1'b0;
        tdi    = 1'b0;
        ext_so = 1'b0;
        strap  = {4'h3, 16'h1234, 11'h0A5, 1'b1};
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R1 reset state
        check("R1", "reset state", {28'd0, tap_state}, 32'hF);
        check("R1", "reset instr", {28'd0, instr}, 32'hE);
        check("R1", "reset chain", {27'd0, chain_sel}, 32'd0);
        check("R1", "reset drive", {31'd0, tdo_drive}, 32'd0);
        check("R1", "reset tdo", {31'd0, tdo}, 32'd0);
        trst_n = 1'b1;

        // R2 and R9: pseudo-random walk against a table model
        model = 4'hF;
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[3]);
            model = ref_next(model, lf[0]);
            check("R2", "walk state", {28'd0, tap_state}, {28'd0, model});
            check("R9", "walk drive", {31'd0, tdo_drive},
                  {31'd0, (model == 4'h2 || model == 4'hA)});
            if (!tdo_drive) check("R9", "walk quiet tdo", {31'd0, tdo}, 32'd0);
        end

        // R1: reset taken from a shift state
        to_idle();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R2", "in shift-dr", {28'd0, tap_state}, 32'h2);
        trst_n = 1'b0;
        step(1'b0, 1'b0);
        trst_n = 1'b1;
        check("R1", "reset from shift", {28'd0, tap_state}, 32'hF);
        check("R1", "drive off after reset", {31'd0, tdo_drive}, 32'd0);
        step(1'b0, 1'b0);

        // R3 and R4: sweep of all instruction codes
        for (int v = 0; v < 16; v++) begin
            scan_ir(v[3:0], q4);
            check("R3", "ir capture pattern", {28'd0, q4}, 32'h1);
            check("R4", "instr loaded", {28'd0, instr}, v);
            check("R9", "idle no drive", {31'd0, tdo_drive}, 32'd0);
        end

        // R4: reset entry reloads the identification code
        scan_ir(4'h5, q4);
        to_idle();
        check("R4", "reset reload instr", {28'd0, instr}, 32'hE);

        // R5: identification with noisy ext_so, two strap values
        scan_dr(32'h0, 32'hFFFF_FFFF, 32, q);
        check("R5", "idcode out", q, strap);
        strap = {4'hA, 16'hBEEF, 11'h3C3, 1'b1};
        scan_dr(32'hFFFF_FFFF, 32'h5555_AAAA, 32, q);
        check("R5", "idcode out 2", q, strap);

        // R7: chain-select sweep
        scan_ir(4'h2, q4);
        prev = chain_sel;
        for (int v = 0; v < 32; v++) begin
            scan_dr({27'd0, v[4:0]}, 32'hFFFF_FFFF, 5, q);
            check("R7", "chain capture", q, {27'd0, prev});
            check("R7", "chain update", {27'd0, chain_sel}, v);
            prev = v[4:0];
        end
        scan_dr(32'd19, 32'h0, 5, q);
        check("R7", "chain set 19", {27'd0, chain_sel}, 32'd19);

        // R6: bypass delays by one; R7: chain untouched
        scan_ir(4'hF, q4);
        scan_dr(32'h0000_01B2, 32'hFFFF_FFFF, 9, q);
        check("R6", "bypass out", q, (32'h0000_01B2 << 1) & 32'h1FF);
        scan_dr(32'h0000_0155, 32'h0, 9, q);
        check("R6", "bypass out 2", q, (32'h0000_0155 << 1) & 32'h1FF);
        check("R7", "chain kept under bypass", {27'd0, chain_sel}, 32'd19);

        // R8: external path
        scan_ir(4'h0, q4);
        scan_dr(32'h1234_5678, 32'hA5C3_96E1, 32, q);
        check("R8", "external out", q, 32'hA5C3_96E1);
        scan_ir(4'h7, q4);
        scan_dr(32'h0, 32'h0F0F_3311, 32, q);
        check("R8", "external out 2", q, 32'h0F0F_3311);
        check("R7", "chain kept under external", {27'd0, chain_sel}, 32'd19);
        tdi = 1'b1;
        #1;
        check("R8", "ext_si high", {31'd0, ext_si}, 32'd1);
        tdi = 1'b0;
        #1;
        check("R8", "ext_si low", {31'd0, ext_si}, 32'd0);

        // R7: reset clears chain number
        to_idle();
        check("R7", "chain cleared", {27'd0, chain_sel}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule